// File: doc/BRIEF.md
# Power-Mode-Aware Reset Aggregator

This block gathers reset requests from six sources and turns them into one registered system reset. The sources are an over-voltage detector, an under-voltage detector, a watchdog expiry, a fetch from an unmapped address, a stop-instruction-disabled event and a missing-clock monitor. Each request passes a qualifier before it counts. The qualifier looks at the present power mode (run, wait or stop), at static option inputs and at an ultra-low-power select. Any request that passes the qualifier asserts the system reset, sets a sticky cause flag and, outside run mode, raises a registered wake request.

The voltage detectors deliver their levels as digital comparator outputs, two per rail. One output trips the condition and the other releases it, which gives hysteresis. These four asynchronous levels cross into the clock domain through a two-stage synchronizer before a set/clear latch per rail holds the condition. When the last qualified request goes away, the reset output stays high for a fixed stretch. Software reads the cause flags and clears them with a write-one-to-clear strobe. An under-voltage reset also wipes them.

Top module: `reset_hub`

## Requirements
- R1: While and after `rst` is high, `sys_rst`, `wake_req` and `cause` are all zero until a qualified request occurs.
- R2: A change on any rail comparator input first affects `sys_rst` on the fourth rising edge after it. This delay is two synchronizer stages, then the rail latch, then the output register.
- R3: The over-voltage condition sets when `hv_above_on` is 1 and clears only when `hv_below_off` is 1 while `hv_above_on` is 0. While it holds, `sys_rst` stays 1 and cause bit 0 is set.
- R4: The under-voltage condition sets when `lv_below_on` is 1 and clears only when `lv_above_off` is 1 while `lv_below_on` is 0. While it holds, `sys_rst` stays 1 and cause bit 1 is set.
- R5: The over-voltage condition is not qualified when `opt_hv_en` is 0 or when `ulp_sel` is 1.
- R6: `cop_req` (cause bit 2) is qualified in run (`pmode`=0) and wait (`pmode`=1) and ignored in stop (`pmode`=2; code 3 also acts as stop).
- R7: `illegal_req` (cause bit 3) and `stopdis_req` (cause bit 4) are qualified only in run mode.
- R8: `clkmon_req` (cause bit 5) is qualified in every mode when `opt_clkmon_en` is 1, and ignored when it is 0.
- R9: `sys_rst` goes high on the edge after a qualified request is seen. It stays high for 16 further edges after the last such edge and falls on the 17th.
- R10: `wake_req` is 1 in the cycle after an edge where a qualified request was present and `pmode` was not run. Otherwise it is 0.
- R11: Cause flags are sticky. A cycle with `clr_stb`=1 clears the bits set in `clr_mask`, but a request qualified in that same cycle sets its bit anyway.
- R12: A qualified under-voltage request clears all other cause flags, leaving bit 1 plus any bits qualified in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_above_on | input | 1 | Supply above over-voltage trip level (async) |
| hv_below_off | input | 1 | Supply below over-voltage release level (async) |
| lv_below_on | input | 1 | Supply below under-voltage trip level (async) |
| lv_above_off | input | 1 | Supply above under-voltage release level (async) |
| cop_req | input | 1 | Watchdog expiry request |
| illegal_req | input | 1 | Unmapped-address fetch request |
| stopdis_req | input | 1 | Stop-disabled event request |
| clkmon_req | input | 1 | Missing-clock request |
| opt_hv_en | input | 1 | Static enable for the over-voltage source |
| opt_clkmon_en | input | 1 | Static enable for the clock-monitor source |
| ulp_sel | input | 1 | Ultra-low-power select, masks over-voltage |
| pmode | input | 2 | Power mode: 0 run, 1 wait, 2/3 stop |
| clr_stb | input | 1 | Write-one-to-clear strobe for cause flags |
| clr_mask | input | 6 | Cause bits cleared by the strobe |
| sys_rst | output | 1 | Stretched system reset |
| wake_req | output | 1 | Request to leave wait or stop |
| cause | output | 6 | Sticky cause flags, bit order as in R3 to R8 |

## Verification
Two updates to the cause flags can land in the same cycle: a clear strobe and a freshly qualified request. The bench sets this up on purpose by raising the watchdog request in the same cycle as a full-mask clear, and it expects the watchdog bit to survive while an older clock-monitor bit is cleared. A second collision is an under-voltage wipe arriving while other flags are set. The random phase produces further overlaps of strobes, mode changes and requests. A cycle-level reference model in the bench judges every cycle.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int NSRC = 6;
  localparam int SRC_HV  = 0;
  localparam int SRC_LV  = 1;
  localparam int SRC_COP = 2;
  localparam int SRC_ILL = 3;
  localparam int SRC_SDR = 4;
  localparam int SRC_CKM = 5;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_STOP = 2'd2,
    PM_STOP_ALT = 2'd3
  } pmode_t;
endpackage

// File: rtl/rh_sync.sv
module rh_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rh_hyst.sv
module rh_hyst (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R3 / R4: trip level forces the held condition
  assert_hyst_set_R3: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R4: release only without trip
  assert_hyst_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/rh_stretch.sv
module rh_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      rst_o <= 1'b0;
    end else begin
      rst_o <= req_i || (cnt != '0);
      if (req_i)           cnt <= CW'(HOLD);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  assert_req_asserts_R9: assert property (@(posedge clk) disable iff (rst)
    req_i |=> rst_o);
  assert_no_early_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> !$past(req_i));
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int HOLD        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hv_above_on,
  input  logic       hv_below_off,
  input  logic       lv_below_on,
  input  logic       lv_above_off,
  input  logic       cop_req,
  input  logic       illegal_req,
  input  logic       stopdis_req,
  input  logic       clkmon_req,
  input  logic       opt_hv_en,
  input  logic       opt_clkmon_en,
  input  logic       ulp_sel,
  input  logic [1:0] pmode,
  input  logic       clr_stb,
  input  logic [5:0] clr_mask,
  output logic       sys_rst,
  output logic       wake_req,
  output logic [5:0] cause
);
  localparam int NCMP = 4;

  logic [NCMP-1:0] cmp_s;
  logic            hv_hold, lv_hold;
  logic [NSRC-1:0] qual;
  logic            any_q, in_run, in_wait;
  pmode_t          pm;

  rh_sync #(.W(NCMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({lv_above_off, lv_below_on, hv_below_off, hv_above_on}),
    .q(cmp_s)
  );

  rh_hyst u_hv (.clk(clk), .rst(rst), .set_i(cmp_s[0]), .clr_i(cmp_s[1]), .q_o(hv_hold));
  rh_hyst u_lv (.clk(clk), .rst(rst), .set_i(cmp_s[2]), .clr_i(cmp_s[3]), .q_o(lv_hold));

  assign pm      = pmode_t'(pmode);
  assign in_run  = (pm == PM_RUN);
  assign in_wait = (pm == PM_WAIT);

  always_comb begin
    qual          = '0;
    qual[SRC_HV]  = hv_hold && opt_hv_en && !ulp_sel;
    qual[SRC_LV]  = lv_hold;
    qual[SRC_COP] = cop_req && (in_run || in_wait);
    qual[SRC_ILL] = illegal_req && in_run;
    qual[SRC_SDR] = stopdis_req && in_run;
    qual[SRC_CKM] = clkmon_req && opt_clkmon_en;
  end

  assign any_q = |qual;

  rh_stretch #(.HOLD(HOLD)) u_str (.clk(clk), .rst(rst), .req_i(any_q), .rst_o(sys_rst));

  always_ff @(posedge clk) begin
    if (rst) begin
      cause    <= '0;
      wake_req <= 1'b0;
    end else begin
      wake_req <= any_q && !in_run;
      if (qual[SRC_LV]) cause <= qual;
      else              cause <= (cause & ~(clr_stb ? clr_mask : 6'd0)) | qual;
    end
  end

  // R11: flags never drop without a strobe or an under-voltage wipe
  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (!clr_stb && !qual[SRC_LV]) |=> ((cause & $past(cause)) == $past(cause)));
  // R10: a wake request always comes with the system reset
  assert_wake_with_rst_R10: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> sys_rst);
  // R6: a watchdog request in stop mode alone never raises the cause bit
  assert_cop_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (!in_run && !in_wait && !clr_stb && !qual[SRC_LV] && !cause[SRC_COP]) |=> !cause[SRC_COP]);
endmodule

// File: tb/reset_hub_test.sv
module reset_hub_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic hv_above_on = 0, hv_below_off = 1, lv_below_on = 0, lv_above_off = 1;
  logic cop_req = 0, illegal_req = 0, stopdis_req = 0, clkmon_req = 0;
  logic opt_hv_en = 1, opt_clkmon_en = 1, ulp_sel = 0;
  logic [1:0] pmode = 0;
  logic clr_stb = 0;
  logic [5:0] clr_mask = 0;
  logic sys_rst, wake_req;
  logic [5:0] cause;

  int total = 0, bad = 0;
  bit cmp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_hub uut (.*);

  // independent cycle model
  logic [3:0] m_s1, m_s2;
  logic m_hv, m_lv, m_rst, m_wake;
  logic [5:0] m_cause;
  int m_cnt;

  function automatic logic [5:0] mqual(logic hv, logic lv);
    logic [5:0] q;
    q[0] = hv && opt_hv_en && !ulp_sel;
    q[1] = lv;
    q[2] = cop_req && (pmode == 2'd0 || pmode == 2'd1);
    q[3] = illegal_req && pmode == 2'd0;
    q[4] = stopdis_req && pmode == 2'd0;
    q[5] = clkmon_req && opt_clkmon_en;
    return q;
  endfunction

  always @(posedge clk) begin
    logic [5:0] q;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_hv = 0; m_lv = 0; m_rst = 0; m_wake = 0; m_cause = 0; m_cnt = 0;
    end else begin
      q = mqual(m_hv, m_lv);
      m_wake = (|q) && pmode != 2'd0;
      m_rst = (|q) || m_cnt != 0;
      m_cnt = (|q) ? 16 : (m_cnt != 0 ? m_cnt - 1 : 0);
      m_cause = (q[1] ? 6'd0 : (m_cause & ~(clr_stb ? clr_mask : 6'd0))) | q;
      if (m_s2[0]) m_hv = 1; else if (m_s2[1]) m_hv = 0;
      if (m_s2[2]) m_lv = 1; else if (m_s2[3]) m_lv = 0;
      m_s2 = m_s1;
      m_s1 = {lv_above_off, lv_below_on, hv_below_off, hv_above_on};
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_stb = 1; clr_mask = 6'h3f; tick(1); clr_stb = 0; clr_mask = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 sys_rst in reset", sys_rst, 0);
    rst = 0; tick(5);
    chk("R1 sys_rst", sys_rst, 0);
    chk("R1 wake", wake_req, 0);
    chk("R1 cause", cause, 0);

    // R6 / R9 watchdog in run, stretch length
    cop_req = 1; tick(1); cop_req = 0;
    chk("R6 cop run rst", sys_rst, 1);
    chk("R6 cop run cause", cause, 6'b000100);
    chk("R10 no wake in run", wake_req, 0);
    tick(16); chk("R9 still high at 16", sys_rst, 1);
    tick(1);  chk("R9 low at 17", sys_rst, 0);

    // R11 clear by strobe
    clr_stb = 1; clr_mask = 6'b000100; tick(1); clr_stb = 0; clr_mask = 0;
    chk("R11 w1c", cause, 0);

    // R6 stop ignores watchdog; wait honours it
    pmode = 2; cop_req = 1; tick(3);
    chk("R6 cop stop rst", sys_rst, 0);
    chk("R6 cop stop cause", cause, 0);
    pmode = 3; tick(2);
    chk("R6 cop stop-alt cause", cause, 0);
    pmode = 1; tick(1); cop_req = 0;
    chk("R6 cop wait rst", sys_rst, 1);
    chk("R10 wake in wait", wake_req, 1);
    chk("R6 cop wait cause", cause, 6'b000100);
    tick(1); chk("R10 wake drops", wake_req, 0);
    tick(20); clear_all();

    // R7 illegal/stopdis only in run
    pmode = 2; illegal_req = 1; stopdis_req = 1; tick(3);
    chk("R7 ignored in stop", {sys_rst, cause}, 0);
    pmode = 1; tick(2);
    chk("R7 ignored in wait", {sys_rst, cause}, 0);
    pmode = 0; tick(1); illegal_req = 0; stopdis_req = 0;
    chk("R7 run cause", cause, 6'b011000);
    tick(20); clear_all();

    // R8 clock monitor gated by option, all modes
    opt_clkmon_en = 0; clkmon_req = 1; tick(3);
    chk("R8 option off", {sys_rst, cause}, 0);
    opt_clkmon_en = 1; pmode = 2; tick(1); clkmon_req = 0;
    chk("R8 stop cause", cause, 6'b100000);
    chk("R10 wake in stop", wake_req, 1);
    tick(20);

    // R11 / R12 set beats clear in same cycle
    pmode = 0; cop_req = 1; clr_stb = 1; clr_mask = 6'h3f; tick(1);
    cop_req = 0; clr_stb = 0; clr_mask = 0;
    chk("R11 set beats clear", cause, 6'b000100);
    tick(20); clear_all();

    // R2 / R3 over-voltage hysteresis
    hv_above_on = 1; hv_below_off = 0; tick(3);
    chk("R2 not yet at edge 3", sys_rst, 0);
    tick(1);
    chk("R2 hv at edge 4", sys_rst, 1);
    chk("R3 hv cause", cause, 6'b000001);
    hv_above_on = 0; tick(30);
    chk("R3 hv held between levels", sys_rst, 1);
    hv_below_off = 1; tick(19);
    chk("R3 hv stretch tail", sys_rst, 1);
    tick(1); chk("R3 hv released", sys_rst, 0);
    clear_all();

    // R5 masking by ulp and option
    ulp_sel = 1; hv_above_on = 1; hv_below_off = 0; tick(25);
    chk("R5 ulp masks hv", {sys_rst, cause}, 0);
    ulp_sel = 0; opt_hv_en = 0; tick(10);
    chk("R5 option masks hv", {sys_rst, cause}, 0);
    hv_above_on = 0; hv_below_off = 1; tick(6);
    opt_hv_en = 1; tick(3);
    chk("R5 unmasked after release", {sys_rst, cause}, 0);

    // R12 / R4 under-voltage wipes flags
    clkmon_req = 1; cop_req = 1; tick(1); clkmon_req = 0; cop_req = 0;
    tick(20);
    chk("R12 setup flags", cause, 6'b100100);
    lv_below_on = 1; lv_above_off = 0; tick(4);
    chk("R12 lv wipes others", cause, 6'b000010);
    chk("R4 lv rst", sys_rst, 1);
    lv_below_on = 0; tick(30);
    chk("R4 lv held between levels", sys_rst, 1);
    lv_above_off = 1; tick(19);
    chk("R4 lv tail", sys_rst, 1);
    tick(1); chk("R4 lv released", sys_rst, 0);
    clear_all();

    // random phase against the model
    void'($urandom(32'h5eed_1234));
    cmp_en = 1;
    for (int i = 0; i < 4000; i++) begin
      chk("R9 model sys_rst", sys_rst, m_rst);
      chk("R10 model wake", wake_req, m_wake);
      chk("R11 model cause", cause, m_cause);
      cop_req     = ($urandom % 16) == 0;
      illegal_req = ($urandom % 24) == 0;
      stopdis_req = ($urandom % 24) == 0;
      clkmon_req  = ($urandom % 32) == 0;
      pmode       = 2'($urandom % 4);
      clr_stb     = ($urandom % 8) == 0;
      clr_mask    = 6'($urandom);
      if (($urandom % 64) == 0) ulp_sel = ~ulp_sel;
      if (($urandom % 64) == 0) hv_above_on = ~hv_above_on;
      if (($urandom % 48) == 0) hv_below_off = ~hv_below_off;
      if (($urandom % 96) == 0) lv_below_on = ~lv_below_on;
      if (($urandom % 48) == 0) lv_above_off = ~lv_above_off;
      tick(1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule